// File: doc/BRIEF.md
# Configurable Aspect-Ratio Two-Port RAM

This block is a synthesizable behavioural model of a 4096-bit on-chip memory with one write port and one read port. Each port runs on its own clock and picks its own shape through a parameter: 16 bits by 256, 8 by 512, 4 by 1024 or 2 by 2048. Both ports see the same linear bit array, so a value stored sixteen bits at a time can be fetched back four bits at a time, or the reverse.

The write port stores data on its active clock edge when both its write enable and its clock enable are high. In the 16-bit write shape a per-bit keep vector, active low, protects individual stored bits. The read port is registered. An enabled read loads the addressed word into the output register, and at any other edge the register keeps its value. The register has no reset, so its content is undefined until the first enabled read. Either port can be made to act on the falling edge of its clock, and the array starts from sixteen 256-bit preload parameters.

Top module: `shape_ram`

## Requirements
- R1: Shape code s (0 = 256x16, 1 = 512x8, 2 = 1024x4, 3 = 2048x2) gives width 16>>s and 8+s address bits. Address bits above that count are ignored, write data bits at or above the width are ignored, and read data bits at or above the width read as 0.
- R2: A word of width W at address A occupies bits A*W up to A*W+W-1 of the 4096-bit array, with bit 0 of the word at the lowest position. Writes and reads of different widths follow this mapping against each other.
- R3: The array changes only at an active write edge where wr_en and wr_clk_en are both 1. If either is 0, the stored contents stay as they were.
- R4: In write shape 0, wr_keep bit i = 0 stores data bit i and wr_keep bit i = 1 leaves stored bit i unchanged. In write shapes 1 to 3, wr_keep has no effect.
- R5: At an active read edge where rd_en and rd_clk_en are both 1, rd_data takes the addressed word and shows it after that edge.
- R6: At an active read edge where rd_en or rd_clk_en is 0, rd_data keeps its previous value.
- R7: Before any write, the array holds {PRELOAD_F, ..., PRELOAD_0}, with PRELOAD_0 supplying bits 255..0.
- R8: When both ports share one clock and a read and a write touch overlapping bits at the same edge, the read returns the contents from before that write.
- R9: WR_FALL = 1 moves the write port to the falling edge of wr_clk, and RD_FALL = 1 does the same for the read port with rd_clk. The default for both is the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_clk_en | input | 1 | Write port clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 11 | Write word address; only the low 8+WR_SHAPE bits are used |
| wr_data | input | 16 | Write data; only the low 16>>WR_SHAPE bits are used |
| wr_keep | input | 16 | Active-low per-bit write mask, used only in write shape 0 |
| rd_clk | input | 1 | Read port clock |
| rd_clk_en | input | 1 | Read port clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 11 | Read word address; only the low 8+RD_SHAPE bits are used |
| rd_data | output | 16 | Registered read word, zero above the read width |

## Verification
The hardest case to reach from the ports is a read and a write landing on the same edge with overlapping bits at different widths. There the ordering between the two ports decides whether the old or the new data comes back. The bench drives both ports from one clock. It issues a 16-bit write and a 4-bit read of a nibble inside the same word in the same cycle, then reads that nibble again on the next cycle. A second instance runs both ports on falling edges, writing 2 bits at a time and reading 8 bits at a time, so that writes are assembled into bytes and read back across the width change. Each expected value comes from a bench-side bit array that applies the address mapping and the mask rules. For a same-edge pair, the bench takes the read value from that array before it applies the write.

// File: rtl/shape_ram_pkg.sv
package shape_ram_pkg;

    localparam int TOTAL_BITS = 4096;
    localparam int LANES      = 16;
    localparam int ADDR_W     = 11;
    localparam int OFS_W      = $clog2(TOTAL_BITS);

    typedef enum logic [1:0] {
        SHAPE_W16 = 2'd0,
        SHAPE_W8  = 2'd1,
        SHAPE_W4  = 2'd2,
        SHAPE_W2  = 2'd3
    } shape_e;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [LANES-1:0] lane_t;

    // One access as seen by the array: first bit position and active lanes
    typedef struct packed {
        ofs_t  base;
        lane_t lanes;
    } span_t;

    function automatic int width_of(input int shape);
        return LANES >> shape;
    endfunction

    function automatic int depth_of(input int shape);
        return TOTAL_BITS / width_of(shape);
    endfunction

    // Bit position of word 'addr'; address bits above the shape's range drop out
    function automatic ofs_t base_of(input int shape, input logic [ADDR_W-1:0] addr);
        int idx;
        idx = int'(addr) % depth_of(shape);
        return ofs_t'(idx * width_of(shape));
    endfunction

    function automatic lane_t lane_fill(input int shape);
        lane_t m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (i < width_of(shape));
        end
        return m;
    endfunction

endpackage

// File: rtl/srm_wr_ctrl.sv
module srm_wr_ctrl
    import shape_ram_pkg::*;
#(
    parameter int SHAPE = 0
) (
    input  logic              wr_en,
    input  logic              wr_clk_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lane_t             wr_keep,
    output span_t             span
);

    localparam lane_t  FILL    = lane_fill(SHAPE);
    localparam shape_e SHAPE_E = shape_e'(SHAPE[1:0]);

    lane_t bit_ok;

    generate
        if (SHAPE_E == SHAPE_W16) begin : g_masked
            assign bit_ok = ~wr_keep;
        end else begin : g_plain
            logic keep_unused;
            assign keep_unused = ^wr_keep;
            assign bit_ok      = '1;
        end
    endgenerate

    always_comb begin
        span.base  = base_of(SHAPE, wr_addr);
        span.lanes = (wr_en && wr_clk_en) ? (FILL & bit_ok) : '0;
    end

endmodule

// File: rtl/srm_bit_array.sv
module srm_bit_array
    import shape_ram_pkg::*;
#(
    parameter int                    SHAPE = 0,
    parameter logic [TOTAL_BITS-1:0] SEED  = '0
) (
    input  logic                  wclk,
    input  logic                  clk_en,
    input  span_t                 span,
    input  lane_t                 wr_data,
    output logic [TOTAL_BITS-1:0] cells
);

    localparam int W = width_of(SHAPE);

    logic [TOTAL_BITS-1:0] mem_q = SEED;

    always_ff @(posedge wclk) begin
        for (int i = 0; i < LANES; i++) begin
            if (span.lanes[i]) begin
                mem_q[span.base + ofs_t'(i)] <= wr_data[i];
            end
        end
        AST_IDLE_NO_WRITE: assert (clk_en || span.lanes == '0)
            else $error("lanes active with write clock disabled"); // R3
        if (SHAPE != 0 && span.lanes != '0) begin
            AST_MASK_IGNORED: assert ($countones(span.lanes) == W)
                else $error("partial write outside 16-bit shape"); // R4
        end
        AST_WR_SPAN: assert ((int'(span.base) % W) == 0 && int'(span.base) + W <= TOTAL_BITS)
            else $error("write span misaligned"); // R2
    end

    assign cells = mem_q;

endmodule

// File: rtl/srm_rd_port.sv
module srm_rd_port
    import shape_ram_pkg::*;
#(
    parameter int SHAPE = 0
) (
    input  logic                  rclk,
    input  logic                  rd_en,
    input  logic                  rd_clk_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [TOTAL_BITS-1:0] cells,
    output lane_t                 rd_data
);

    localparam int W = width_of(SHAPE);

    ofs_t  base;
    lane_t word;
    lane_t data_q;

    always_comb begin
        base = base_of(SHAPE, rd_addr);
        word = '0;
        for (int i = 0; i < W; i++) begin
            word[i] = cells[base + ofs_t'(i)];
        end
    end

    // Output register deliberately has no reset
    always_ff @(posedge rclk) begin
        if (rd_en && rd_clk_en) begin
            data_q <= word;
            AST_RD_SPAN: assert ((int'(base) % W) == 0 && int'(base) + W <= TOTAL_BITS)
                else $error("read span misaligned"); // R2
        end
    end

    assign rd_data = data_q;

endmodule

// File: rtl/shape_ram.sv
module shape_ram
    import shape_ram_pkg::*;
#(
    parameter int           WR_SHAPE  = 0,
    parameter int           RD_SHAPE  = 0,
    parameter bit           WR_FALL   = 1'b0,
    parameter bit           RD_FALL   = 1'b0,
    parameter logic [255:0] PRELOAD_0 = '0,
    parameter logic [255:0] PRELOAD_1 = '0,
    parameter logic [255:0] PRELOAD_2 = '0,
    parameter logic [255:0] PRELOAD_3 = '0,
    parameter logic [255:0] PRELOAD_4 = '0,
    parameter logic [255:0] PRELOAD_5 = '0,
    parameter logic [255:0] PRELOAD_6 = '0,
    parameter logic [255:0] PRELOAD_7 = '0,
    parameter logic [255:0] PRELOAD_8 = '0,
    parameter logic [255:0] PRELOAD_9 = '0,
    parameter logic [255:0] PRELOAD_A = '0,
    parameter logic [255:0] PRELOAD_B = '0,
    parameter logic [255:0] PRELOAD_C = '0,
    parameter logic [255:0] PRELOAD_D = '0,
    parameter logic [255:0] PRELOAD_E = '0,
    parameter logic [255:0] PRELOAD_F = '0
) (
    input  logic        wr_clk,
    input  logic        wr_clk_en,
    input  logic        wr_en,
    input  logic [10:0] wr_addr,
    input  logic [15:0] wr_data,
    input  logic [15:0] wr_keep,
    input  logic        rd_clk,
    input  logic        rd_clk_en,
    input  logic        rd_en,
    input  logic [10:0] rd_addr,
    output logic [15:0] rd_data
);

    localparam logic [TOTAL_BITS-1:0] SEED = {
        PRELOAD_F, PRELOAD_E, PRELOAD_D, PRELOAD_C,
        PRELOAD_B, PRELOAD_A, PRELOAD_9, PRELOAD_8,
        PRELOAD_7, PRELOAD_6, PRELOAD_5, PRELOAD_4,
        PRELOAD_3, PRELOAD_2, PRELOAD_1, PRELOAD_0
    };

    // Polarity option: inverting the clock turns a falling edge into a rising one
    logic wclk_eff;
    logic rclk_eff;
    assign wclk_eff = wr_clk ^ WR_FALL;
    assign rclk_eff = rd_clk ^ RD_FALL;

    span_t                 wr_span;
    logic [TOTAL_BITS-1:0] cells;

    srm_wr_ctrl #(
        .SHAPE (WR_SHAPE)
    ) u_wr_ctrl (
        .wr_en     (wr_en),
        .wr_clk_en (wr_clk_en),
        .wr_addr   (wr_addr),
        .wr_keep   (wr_keep),
        .span      (wr_span)
    );

    srm_bit_array #(
        .SHAPE (WR_SHAPE),
        .SEED  (SEED)
    ) u_array (
        .wclk    (wclk_eff),
        .clk_en  (wr_clk_en),
        .span    (wr_span),
        .wr_data (wr_data),
        .cells   (cells)
    );

    srm_rd_port #(
        .SHAPE (RD_SHAPE)
    ) u_rd_port (
        .rclk      (rclk_eff),
        .rd_en     (rd_en),
        .rd_clk_en (rd_clk_en),
        .rd_addr   (rd_addr),
        .cells     (cells),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/shape_ram_tb_top.sv
`timescale 1ns/1ps
module shape_ram_tb_top;

    localparam int A_WR = 0;
    localparam int A_RD = 2;
    localparam int B_WR = 3;
    localparam int B_RD = 1;

    localparam logic [255:0] A_P0 = 256'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    localparam logic [255:0] A_PF = 256'hDEAD_BEEF_CAFE_F00D_1357_9BDF_2468_ACE0_5A5A_A5A5_3C3C_C3C3_0000_FFFF_1111_EEEE;
    localparam logic [255:0] B_P3 = 256'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F_1032_5476_98BA_DCFE_EFCD_AB89_6745_2301;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic        a_wce = 0, a_we = 0, a_rce = 0, a_re = 0;
    logic [10:0] a_wa = 0, a_ra = 0;
    logic [15:0] a_wd = 0, a_kp = 0;
    logic [15:0] a_rd;
    logic        b_wce = 0, b_we = 0, b_rce = 0, b_re = 0;
    logic [10:0] b_wa = 0, b_ra = 0;
    logic [15:0] b_wd = 0, b_kp = 0;
    logic [15:0] b_rd;

    logic [4095:0] ref_a = {A_PF, {14{256'h0}}, A_P0};
    logic [4095:0] ref_b = {{12{256'h0}}, B_P3, {3{256'h0}}};
    logic [15:0]   last_a = 0, last_b = 0;
    item_t         qa[$];
    item_t         qb[$];

    shape_ram #(
        .WR_SHAPE (A_WR), .RD_SHAPE (A_RD),
        .PRELOAD_0 (A_P0), .PRELOAD_F (A_PF)
    ) dut_i (
        .wr_clk (clk), .wr_clk_en (a_wce), .wr_en (a_we), .wr_addr (a_wa),
        .wr_data (a_wd), .wr_keep (a_kp),
        .rd_clk (clk), .rd_clk_en (a_rce), .rd_en (a_re), .rd_addr (a_ra),
        .rd_data (a_rd)
    );

    shape_ram #(
        .WR_SHAPE (B_WR), .RD_SHAPE (B_RD),
        .WR_FALL (1'b1), .RD_FALL (1'b1),
        .PRELOAD_3 (B_P3)
    ) dut_b (
        .wr_clk (clk), .wr_clk_en (b_wce), .wr_en (b_we), .wr_addr (b_wa),
        .wr_data (b_wd), .wr_keep (b_kp),
        .rd_clk (clk), .rd_clk_en (b_rce), .rd_en (b_re), .rd_addr (b_ra),
        .rd_data (b_rd)
    );

    // Reference model, written from the mapping and mask rules
    function automatic logic [15:0] ref_read(input logic [4095:0] m, input int shp, input logic [10:0] a);
        int w = 16 >> shp;
        int idx = int'(a) % (4096 / w);
        logic [15:0] v = '0;
        for (int i = 0; i < w; i++) v[i] = m[idx * w + i];
        return v;
    endfunction

    function automatic logic [4095:0] ref_write(input logic [4095:0] m, input int shp, input logic [10:0] a,
                                                input logic [15:0] d, input logic [15:0] kp);
        int w = 16 >> shp;
        int idx = int'(a) % (4096 / w);
        logic [4095:0] r = m;
        for (int i = 0; i < w; i++) if (shp != 0 || !kp[i]) r[idx * w + i] = d[i];
        return r;
    endfunction

    task automatic check(input logic [15:0] got, input item_t it);
        checks++;
        if (got !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
    endtask

    // Driver for the rising-edge instance: inputs change on the falling edge
    task automatic cyc_a(input logic we, input logic wce, input logic [10:0] wa, input logic [15:0] wd,
                         input logic [15:0] kp, input logic re, input logic rce, input logic [10:0] ra,
                         input string tag);
        item_t it;
        @(negedge clk);
        a_we = we; a_wce = wce; a_wa = wa; a_wd = wd; a_kp = kp;
        a_re = re; a_rce = rce; a_ra = ra;
        it.exp = (re && rce) ? ref_read(ref_a, A_RD, ra) : last_a;
        it.tag = tag;
        last_a = it.exp;
        qa.push_back(it);
        if (we && wce) ref_a = ref_write(ref_a, A_WR, wa, wd, kp);
    endtask

    // Driver for the falling-edge instance: inputs change on the rising edge
    task automatic cyc_b(input logic we, input logic wce, input logic [10:0] wa, input logic [15:0] wd,
                         input logic [15:0] kp, input logic re, input logic rce, input logic [10:0] ra,
                         input string tag);
        item_t it;
        @(posedge clk);
        b_we = we; b_wce = wce; b_wa = wa; b_wd = wd; b_kp = kp;
        b_re = re; b_rce = rce; b_ra = ra;
        it.exp = (re && rce) ? ref_read(ref_b, B_RD, ra) : last_b;
        it.tag = tag;
        last_b = it.exp;
        qb.push_back(it);
        if (we && wce) ref_b = ref_write(ref_b, B_WR, wa, wd, kp);
    endtask

    // Monitors: an item becomes due once its active edge has passed
    initial begin
        int due;
        item_t it;
        forever begin
            @(posedge clk);
            due = qa.size();
            @(negedge clk);
            for (int k = 0; k < due; k++) begin
                it = qa.pop_front();
                check(a_rd, it);
            end
        end
    end

    initial begin
        int due;
        item_t it;
        forever begin
            @(negedge clk);
            due = qb.size();
            @(posedge clk);
            for (int k = 0; k < due; k++) begin
                it = qb.pop_front();
                check(b_rd, it);
            end
        end
    end

    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Instance A: 16-bit writes, 4-bit reads, rising edges
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'd0,    "R7 preload lowest nibble");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'd1023, "R7 preload highest nibble");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'd5,    "R2 R5 preload nibble 5");
        cyc_a(1, 1, 11'd5, 16'hC0DE, 16'h0000, 0, 1, 11'd0, "R6 read enable low holds");
        for (int n = 20; n < 24; n++) cyc_a(0, 0, 0, 0, 0, 1, 1, 11'(n), "R2 R3 nibble of 16-bit write");
        cyc_a(1, 1, 11'd5, 16'h1234, 16'hFF00, 1, 0, 11'd3, "R6 read clock enable low holds");
        for (int n = 20; n < 24; n++) cyc_a(0, 0, 0, 0, 0, 1, 1, 11'(n), "R4 masked write keeps upper byte");
        cyc_a(1, 0, 11'd6, 16'hFFFF, 16'h0000, 1, 1, 11'd24, "R3 write clock enable low");
        cyc_a(0, 1, 11'd6, 16'hFFFF, 16'h0000, 1, 1, 11'd24, "R3 write enable low");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'd27, "R3 word 6 untouched");
        cyc_a(1, 1, 11'd7, 16'h5555, 16'h0000, 1, 1, 11'd28, "R8 first write, old read");
        cyc_a(1, 1, 11'd7, 16'hAAAA, 16'h0000, 1, 1, 11'd28, "R8 same edge read sees old bits");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'd28, "R8 next read sees new bits");
        cyc_a(1, 1, 11'h7FF, 16'h9876, 16'h0000, 1, 1, 11'd1022, "R1 upper write address bits ignored");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'h7FF, "R1 upper read address bit ignored");
        cyc_a(0, 0, 0, 0, 0, 1, 1, 11'h400, "R1 read address wraps to nibble 0");
        cyc_a(0, 0, 0, 0, 0, 0, 0, 0, "R6 idle holds");
        @(negedge clk);
        a_re = 0; a_rce = 0; a_we = 0; a_wce = 0;
        repeat (3) @(negedge clk);

        // Instance B: 2-bit writes, 8-bit reads, falling edges
        cyc_b(0, 0, 0, 0, 0, 1, 1, 11'd96,  "R7 R9 preload block 3 first byte");
        cyc_b(0, 0, 0, 0, 0, 1, 1, 11'd127, "R7 R9 preload block 3 last byte");
        cyc_b(1, 1, 11'd40, 16'hFFFD, 16'hFFFF, 1, 1, 11'd10, "R4 keep ignored in narrow shape");
        cyc_b(1, 1, 11'd41, 16'h0002, 16'hFFFF, 0, 1, 11'd10, "R6 read disabled holds");
        cyc_b(1, 1, 11'd42, 16'hAAA3, 16'hFFFF, 0, 0, 11'd10, "R6 both read enables low");
        cyc_b(1, 1, 11'd43, 16'h0000, 16'hFFFF, 1, 1, 11'd10, "R8 byte read same edge as write");
        cyc_b(0, 0, 0, 0, 0, 1, 1, 11'd10, "R1 R2 bytes assembled from 2-bit writes");
        cyc_b(1, 1, 11'd385, 16'h0003, 16'h0000, 1, 1, 11'd96, "R2 write into preloaded byte");
        cyc_b(0, 0, 0, 0, 0, 1, 1, 11'd96, "R2 R9 preloaded byte updated");
        cyc_b(1, 0, 11'd384, 16'h0003, 16'h0000, 1, 1, 11'd96, "R3 clock enable low no write");
        cyc_b(0, 0, 0, 0, 0, 1, 1, 11'd96, "R3 byte unchanged");
        @(posedge clk);
        b_re = 0; b_rce = 0; b_we = 0; b_wce = 0;
        repeat (4) @(negedge clk);

        if (qa.size() != 0 || qb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R5: got %0d pending expected 0", qa.size() + qb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule